// File: doc/BRIEF.md
# Transmit I/Q Playout Buffer with Idle Substitution

This block sits between a bursty host link and a transmit DAC path. Packed I/Q words arrive through a valid/ready write port in whole blocks, and a marker flags the last word of each block. A free-running sample-rate strobe from the DAC side pulls one word per strobe. Playout waits until a programmable number of blocks is queued, so short host stalls do not starve the converters. The prefill depth therefore sets the added latency.

When the queue runs dry, the outputs never keep the last word. A held full-scale word would radiate a full-power carrier. The block drives a software-chosen idle I/Q pair instead, picked to cancel carrier feedthrough at the upconverter. It then drops back to the prefill state. A sticky flag and a saturating event counter record underruns, and the current occupancy is always visible. A synchronous flush empties the queue and returns the block to prefill.

Top module: `iqpb_playout`

## Requirements
- R1: A write word carries I in bits 31:16 and Q in bits 15:0. Both are 16-bit two's complement and appear unchanged on `dac_i` and `dac_q`.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. Words are played in the order they were accepted.
- R3: Out of play, a strobe drives the idle pair. Play starts one clock after either of two conditions holds. The first is that the queue is non-empty and the count of accepted last-marked words since arming reaches `prefill_blocks`, with the value clamped to NUM_BLKS. The second is that the queue is full. A setting of 0 starts play on any queued word.
- R4: In play, a strobe with a non-empty queue pops the head word. The word shows on the outputs after that edge, and the outputs hold between strobes.
- R5: In play, a strobe with an empty queue drives the idle pair and never repeats the previous word. Play then stops and re-arms per R3.
- R6: `underrun_flag` sets on an underrun strobe. A pulse on `underrun_clr` clears it, and a set in the same cycle wins.
- R7: `underrun_count` adds one per underrun event and saturates at its all-ones value.
- R8: With the queue full, `in_ready` is low. No stored word is overwritten and no word is dropped.
- R9: `flush` empties the queue, leaves play, clears the block count and loads the idle pair on the outputs at the next edge.
- R10: `fill_level` equals the number of stored words.
- R11: After reset, the outputs are zero, `in_ready` is high, and the queue is empty, out of play and free of underrun history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue and re-arm |
| in_valid | input | 1 | Write word valid |
| in_ready | output | 1 | Queue can accept a word |
| in_word | input | 32 | Packed I (31:16) / Q (15:0) |
| in_last | input | 1 | Word ends a block |
| prefill_blocks | input | $clog2(NUM_BLKS+1) | Blocks needed before play |
| idle_i | input | 16 | Idle I value |
| idle_q | input | 16 | Idle Q value |
| dac_strobe | input | 1 | Sample-rate strobe |
| dac_i | output | 16 | I sample to DAC |
| dac_q | output | 16 | Q sample to DAC |
| playing | output | 1 | Play state |
| underrun_flag | output | 1 | Sticky underrun indication |
| underrun_clr | input | 1 | Clear for the sticky flag |
| underrun_count | output | UR_CNT_W | Saturating underrun event count |
| fill_level | output | $clog2(BLK_LEN*NUM_BLKS+1) | Stored word count |

## Verification
The hardest states to reach are the ones where play and occupancy change together. One is an underrun on a strobe right after the last word is popped. Another is a start triggered by a full queue with no block markers at all. A third is a counter driven into saturation. The bench shrinks the block length, block count and counter width through parameters. It then writes exact word counts so that a chosen strobe meets an empty queue. For saturation, it repeats a short cycle of single-word prefill, pop and starve until the counter reaches its limit.

// File: rtl/iqpb_pkg.sv
package iqpb_pkg;
    localparam int SAMPLE_W = 16;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] i;
        logic signed [SAMPLE_W-1:0] q;
    } iq_t;
endpackage

// File: rtl/iqpb_store.sv
module iqpb_store
    import iqpb_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  iq_t                        wdata,
    input  logic                       pop,
    output iq_t                        rdata,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
    } st_t;

    st_t st_d, st_q;
    iq_t mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.lvl = '0;
        end else begin
            if (push) st_d.wr = (st_q.wr == AW'(DEPTH-1)) ? '0 : st_q.wr + 1'b1;
            if (pop)  st_d.rd = (st_q.rd == AW'(DEPTH-1)) ? '0 : st_q.rd + 1'b1;
            case ({push, pop})
                2'b10:   st_d.lvl = st_q.lvl + 1'b1;
                2'b01:   st_d.lvl = st_q.lvl - 1'b1;
                default: st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[st_q.wr] <= wdata;
    end

    assign rdata = mem[st_q.rd];
    assign full  = (st_q.lvl == LW'(DEPTH));
    assign empty = (st_q.lvl == '0);
    assign level = st_q.lvl;
endmodule

// File: rtl/iqpb_ctrl.sv
module iqpb_ctrl
    import iqpb_pkg::*;
#(
    parameter int NUM_BLKS = 8,
    parameter int UR_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          strobe,
    input  logic                          empty,
    input  logic                          full,
    input  iq_t                           head,
    input  logic                          blk_done,
    input  logic [$clog2(NUM_BLKS+1)-1:0] prefill,
    input  iq_t                           idle,
    input  logic                          ur_clr,
    output logic                          pop,
    output iq_t                           dac,
    output logic                          playing,
    output logic                          ur_flag,
    output logic [UR_W-1:0]               ur_cnt
);
    localparam int BC_W = $clog2(NUM_BLKS+1);

    typedef struct packed {
        logic            playing;
        logic [BC_W-1:0] blk_cnt;
        iq_t             out;
        logic            flag;
        logic [UR_W-1:0] cnt;
    } st_t;

    st_t             st_d, st_q;
    logic [BC_W-1:0] thr;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        thr  = (prefill > BC_W'(NUM_BLKS)) ? BC_W'(NUM_BLKS) : prefill;
        if (ur_clr) st_d.flag = 1'b0;
        if (flush) begin
            st_d.playing = 1'b0;
            st_d.blk_cnt = '0;
            st_d.out     = idle;
        end else if (st_q.playing) begin
            st_d.blk_cnt = '0;
            if (strobe) begin
                if (!empty) begin
                    pop      = 1'b1;
                    st_d.out = head;
                end else begin
                    st_d.out     = idle;
                    st_d.playing = 1'b0;
                    st_d.flag    = 1'b1;
                    if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin
            if (blk_done && st_q.blk_cnt != BC_W'(NUM_BLKS))
                st_d.blk_cnt = st_q.blk_cnt + 1'b1;
            if (strobe) st_d.out = idle;
            if ((st_q.blk_cnt >= thr && !empty) || full) st_d.playing = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dac     = st_q.out;
    assign playing = st_q.playing;
    assign ur_flag = st_q.flag;
    assign ur_cnt  = st_q.cnt;
endmodule

// File: rtl/iqpb_playout.sv
module iqpb_playout
    import iqpb_pkg::*;
#(
    parameter int BLK_LEN  = 64,
    parameter int NUM_BLKS = 8,
    parameter int UR_CNT_W = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     flush,
    input  logic                                     in_valid,
    output logic                                     in_ready,
    input  logic [2*SAMPLE_W-1:0]                    in_word,
    input  logic                                     in_last,
    input  logic [$clog2(NUM_BLKS+1)-1:0]            prefill_blocks,
    input  logic [SAMPLE_W-1:0]                      idle_i,
    input  logic [SAMPLE_W-1:0]                      idle_q,
    input  logic                                     dac_strobe,
    output logic [SAMPLE_W-1:0]                      dac_i,
    output logic [SAMPLE_W-1:0]                      dac_q,
    output logic                                     playing,
    output logic                                     underrun_flag,
    input  logic                                     underrun_clr,
    output logic [UR_CNT_W-1:0]                      underrun_count,
    output logic [$clog2(BLK_LEN*NUM_BLKS+1)-1:0]    fill_level
);
    localparam int DEPTH = BLK_LEN * NUM_BLKS;

    logic push, pop, full, empty, blk_done;
    iq_t  head, idle_pair, out_pair;

    assign in_ready  = !full;
    assign push      = in_valid && in_ready && !flush;
    assign blk_done  = push && in_last;
    assign idle_pair = '{i: idle_i, q: idle_q};

    iqpb_store #(.DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .wdata (iq_t'(in_word)),
        .pop   (pop),
        .rdata (head),
        .full  (full),
        .empty (empty),
        .level (fill_level)
    );

    iqpb_ctrl #(.NUM_BLKS(NUM_BLKS), .UR_W(UR_CNT_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .strobe   (dac_strobe),
        .empty    (empty),
        .full     (full),
        .head     (head),
        .blk_done (blk_done),
        .prefill  (prefill_blocks),
        .idle     (idle_pair),
        .ur_clr   (underrun_clr),
        .pop      (pop),
        .dac      (out_pair),
        .playing  (playing),
        .ur_flag  (underrun_flag),
        .ur_cnt   (underrun_count)
    );

    assign dac_i = out_pair.i;
    assign dac_q = out_pair.q;
endmodule

module iqpb_playout_chk #(
    parameter int DEPTH = 512,
    parameter int LVL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_ready,
    input logic             dac_strobe,
    input logic             playing,
    input logic             underrun_flag,
    input logic [15:0]      idle_i,
    input logic [15:0]      idle_q,
    input logic [15:0]      dac_i,
    input logic [15:0]      dac_q,
    input logic [LVL_W-1:0] fill_level
);
    a_r3_idle_while_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_strobe && !playing) |=> (dac_i == $past(idle_i) && dac_q == $past(idle_q)));

    a_r5_starve_gives_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_strobe && playing && fill_level == '0 && !flush)
        |=> (!playing && dac_i == $past(idle_i) && dac_q == $past(idle_q)));

    a_r6_flag_on_starve: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_strobe && playing && fill_level == '0 && !flush) |=> underrun_flag);

    a_r8_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == LVL_W'(DEPTH)) |-> !in_ready);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_level == '0 && !playing));

    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));
endmodule

bind iqpb_playout iqpb_playout_chk #(
    .DEPTH (BLK_LEN*NUM_BLKS),
    .LVL_W ($clog2(BLK_LEN*NUM_BLKS+1))
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .in_ready      (in_ready),
    .dac_strobe    (dac_strobe),
    .playing       (playing),
    .underrun_flag (underrun_flag),
    .idle_i        (idle_i),
    .idle_q        (idle_q),
    .dac_i         (dac_i),
    .dac_q         (dac_q),
    .fill_level    (fill_level)
);

// File: tb/iqpb_playout_tb_top.sv
`timescale 1ns/1ps
module iqpb_playout_tb_top;
    localparam int BLK  = 4;
    localparam int NBLK = 4;
    localparam int DEP  = BLK * NBLK;
    localparam int URW  = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        flush = 0;
    logic        in_valid = 0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        in_last = 0;
    logic [2:0]  prefill_blocks = '0;
    logic [15:0] idle_i = 16'h0012;
    logic [15:0] idle_q = 16'hFFF0;
    logic        dac_strobe = 0;
    logic [15:0] dac_i, dac_q;
    logic        playing, underrun_flag;
    logic        underrun_clr = 0;
    logic [URW-1:0] underrun_count;
    logic [4:0]  fill_level;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  seq   = 0;

    always #2 clk = ~clk;

    iqpb_playout #(.BLK_LEN(BLK), .NUM_BLKS(NBLK), .UR_CNT_W(URW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_last(in_last),
        .prefill_blocks(prefill_blocks), .idle_i(idle_i), .idle_q(idle_q),
        .dac_strobe(dac_strobe), .dac_i(dac_i), .dac_q(dac_q), .playing(playing),
        .underrun_flag(underrun_flag), .underrun_clr(underrun_clr),
        .underrun_count(underrun_count), .fill_level(fill_level)
    );

    function automatic logic [31:0] word_of(int n);
        return {16'(n * 3 + 100), 16'(-n - 1)};
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(logic [31:0] w, bit last, output bit acc);
        @(negedge clk);
        in_valid = 1; in_word = w; in_last = last;
        acc = in_ready;
        @(posedge clk);
        #1 in_valid = 0; in_last = 0;
    endtask

    task automatic push_block(int first);
        bit acc;
        for (int k = 0; k < BLK; k++) push_word(word_of(first + k), k == BLK - 1, acc);
    endtask

    task automatic strobe_once(bit clr = 0);
        @(negedge clk);
        dac_strobe = 1; underrun_clr = clr;
        @(posedge clk);
        #1 dac_strobe = 0; underrun_clr = 0;
        @(negedge clk);
    endtask

    task automatic expect_word(string req, int n);
        logic [31:0] e = word_of(n);
        check({dac_i, dac_q} == e, req, {dac_i, dac_q}, e);
    endtask

    task automatic expect_idle(string req);
        check(dac_i == idle_i && dac_q == idle_q, req, {dac_i, dac_q}, {idle_i, idle_q});
    endtask

    task automatic t_reset;
        check(dac_i == 0 && dac_q == 0, "R11 outputs", {dac_i, dac_q}, 0);
        check(in_ready == 1, "R11 ready", in_ready, 1);
        check(playing == 0 && underrun_flag == 0, "R11 state", {playing, underrun_flag}, 0);
        check(underrun_count == 0, "R11 count", underrun_count, 0);
        check(fill_level == 0, "R11 level", fill_level, 0);
    endtask

    task automatic t_prefill;
        prefill_blocks = 2;
        push_block(0);
        wait_cyc(3);
        check(playing == 0, "R3 one block of two", playing, 0);
        strobe_once();
        expect_idle("R3 idle while armed");
        check(fill_level == BLK, "R10 level one block", fill_level, BLK);
        push_block(BLK);
        wait_cyc(2);
        check(playing == 1, "R3 start at prefill", playing, 1);
        check(fill_level == 2 * BLK, "R10 level two blocks", fill_level, 2 * BLK);
    endtask

    task automatic t_order_and_starve;
        strobe_once();
        expect_word("R1 R4 first word", 0);
        wait_cyc(3);
        expect_word("R4 hold between strobes", 0);
        for (int k = 1; k < 2 * BLK; k++) begin
            strobe_once();
            expect_word("R2 R4 order", k);
        end
        check(fill_level == 0, "R10 drained", fill_level, 0);
        strobe_once();
        expect_idle("R5 idle not last word");
        check(playing == 0, "R5 leaves play", playing, 0);
        check(underrun_flag == 1, "R6 flag set", underrun_flag, 1);
        check(underrun_count == 1, "R7 count one", underrun_count, 1);
    endtask

    task automatic t_rearm_flush;
        push_block(20);
        wait_cyc(3);
        check(playing == 0, "R5 rearm waits full prefill", playing, 0);
        strobe_once();
        expect_idle("R5 idle during rearm");
        push_block(24);
        wait_cyc(2);
        check(playing == 1, "R5 rearmed", playing, 1);
        strobe_once();
        expect_word("R5 play after rearm", 20);
        @(negedge clk); flush = 1;
        @(posedge clk); #1 flush = 0;
        @(negedge clk);
        check(fill_level == 0, "R9 flush empties", fill_level, 0);
        check(playing == 0, "R9 flush leaves play", playing, 0);
        expect_idle("R9 flush idle out");
        check(underrun_flag == 1, "R6 flag sticky", underrun_flag, 1);
        @(negedge clk); underrun_clr = 1;
        @(posedge clk); #1 underrun_clr = 0;
        @(negedge clk);
        check(underrun_flag == 0, "R6 clear", underrun_flag, 0);
        check(underrun_count == 1, "R7 count kept", underrun_count, 1);
    endtask

    task automatic t_full;
        bit acc;
        prefill_blocks = 4;
        for (int k = 0; k < DEP; k++) push_word(word_of(40 + k), 0, acc);
        check(in_ready == 0, "R8 ready low when full", in_ready, 0);
        push_word(word_of(99), 0, acc);
        check(acc == 0, "R8 write refused", acc, 0);
        wait_cyc(2);
        check(playing == 1, "R3 start on full", playing, 1);
        check(fill_level == DEP, "R8 level capped", fill_level, DEP);
        for (int k = 0; k < DEP; k++) begin
            strobe_once();
            expect_word("R8 no overwrite", 40 + k);
        end
        strobe_once();
        expect_idle("R8 extra word absent");
        check(underrun_count == 2, "R7 count two", underrun_count, 2);
    endtask

    task automatic t_zero_prefill_and_sat;
        bit acc;
        prefill_blocks = 0;
        push_word(word_of(7), 0, acc);
        wait_cyc(2);
        check(playing == 1, "R3 zero prefill", playing, 1);
        strobe_once();
        expect_word("R3 zero prefill word", 7);
        for (int r = 0; r < 14; r++) begin
            strobe_once();
            push_word(word_of(r), 0, acc);
            wait_cyc(2);
            strobe_once();
        end
        strobe_once(1);
        check(underrun_flag == 1, "R6 set wins over clear", underrun_flag, 1);
        check(underrun_count == (1 << URW) - 1, "R7 saturates", underrun_count, (1 << URW) - 1);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(1);
        t_reset();
        t_prefill();
        t_order_and_starve();
        t_rearm_flush();
        t_full();
        t_zero_prefill_and_sat();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule